// File: doc/BRIEF.md
# Pipeline Redirect and Fault Capture Controller

This block steers fetch and squashes wrong-path work in a five-stage in-order pipeline. The pipeline fetches straight ahead on the assumption that a branch falls through. The branch outcome is only known once the branch reaches the memory stage. When that stage reports a taken branch, the block selects the branch target as the next fetch address. It also discards the three younger instructions, and each stage is discarded in its own way. The instruction word entering the fetch/decode register is zeroed. The decoded control bits entering the decode/execute register are forced to zero. The ALU result and write enable leaving execute are zeroed by an extra multiplexer.

The same block turns faults into precise traps. A fault can be an undefined opcode or a system call seen in decode, an arithmetic overflow seen in execute, or an external device request attached to the instruction in the memory stage. Instructions older than the faulting one run to completion. The faulting instruction and everything younger are squashed, so the faulting instruction never writes a register. The faulting instruction's address is stored in an exception PC register and a cause code is stored in a cause register, and fetch jumps to a fixed handler address.

All steering and squash outputs are combinational in the cycle of the event. The exception PC and cause registers load on the following clock edge.

Top module: `pipe_redirect_ctrl`

## Requirements
- R1: After reset, `epc` and `cause` are 0 and, with no event pending, `pcSel` is 0 (sequential).
- R2: With no branch and no fault, `pcSel` is 0, `nextPc` equals `pcPlus4`, all flush outputs are 0 and the instruction word, the decode control bits, the ALU result and both write enables pass through unchanged.
- R3: A taken branch with no fault drives `pcSel` to 1 and `nextPc` to `brTarget`. In the same cycle it sets `flushIfId`, `flushIdEx` and `flushExMem`, zeroes `ifIdInstrOut`, `idCtrlOut`, `exAluOut` and `exWrEnOut`, and leaves `memWrEnOut` equal to `memWrEnIn`.
- R4: Any fault drives `pcSel` to 2 and `nextPc` to the handler address parameter (default 0x40000040).
- R5: On the clock edge after a fault, `cause` holds the code of the winning fault (device request 0, system call 8, undefined opcode 10, overflow 12) and `epc` holds the PC of the stage that faulted.
- R6: When several faults arrive together, the oldest stage wins: memory before execute before decode. Within decode an undefined opcode wins over a system call.
- R7: A fault takes priority over a taken branch in the same cycle: `pcSel` is 2 and `nextPc` is the handler address.
- R8: An overflow in execute squashes the fetch, decode and execute stages (ALU result and write enable zeroed) while `memWrEnOut` still follows `memWrEnIn`.
- R9: A decode-stage fault squashes only the fetch and decode stages: `flushExMem` is 0 and `exAluOut` and `exWrEnOut` pass through.
- R10: A device request on the memory stage squashes fetch, decode and execute and forces `memWrEnOut` to 0.
- R11: `epc` and `cause` keep their values through any cycle without a fault, including cycles with a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brTaken | input | 1 | Branch in memory stage resolved taken |
| brTarget | input | 32 | Target of that branch |
| pcPlus4 | input | 32 | Sequential next fetch address |
| idPc | input | 32 | PC of instruction in decode |
| exPc | input | 32 | PC of instruction in execute |
| memPc | input | 32 | PC of instruction in memory stage |
| idUndef | input | 1 | Decode sees an undefined opcode |
| idSyscall | input | 1 | Decode sees a system call |
| exOvf | input | 1 | Execute reports arithmetic overflow |
| memIrq | input | 1 | External device request taken at memory-stage instruction |
| ifIdInstrIn | input | 32 | Fetched word headed for fetch/decode register |
| idCtrlIn | input | 8 | Decoded control bits headed for decode/execute register |
| exAluIn | input | 32 | ALU result headed for execute/memory register |
| exWrEnIn | input | 1 | Register write enable of execute instruction |
| memWrEnIn | input | 1 | Register write enable of memory-stage instruction |
| pcSel | output | 2 | Fetch source: 0 sequential, 1 branch target, 2 handler |
| nextPc | output | 32 | Selected next fetch address |
| flushIfId | output | 1 | Fetch/decode register receives a squashed entry |
| flushIdEx | output | 1 | Decode/execute register receives a squashed entry |
| flushExMem | output | 1 | Execute/memory register receives a squashed entry |
| ifIdInstrOut | output | 32 | Instruction word after squash mux |
| idCtrlOut | output | 8 | Control bits after squash mux |
| exAluOut | output | 32 | ALU result after squash mux |
| exWrEnOut | output | 1 | Execute write enable after squash mux |
| memWrEnOut | output | 1 | Memory-stage write enable after fault kill |
| epc | output | 32 | Captured faulting PC |
| cause | output | 5 | Captured cause code |

## Verification
The assertions assume that the fault inputs are synchronous and already qualified by the pipeline. A request reported for a stage belongs to the instruction whose PC is on that stage's PC input in the same cycle. Each fault input stays high for exactly the cycle in which the trap is taken. The bench drives every request for one cycle only, between a falling edge and the next rising edge, with the stage PCs held steady. It then returns all requests to zero, so no request lingers into the cycle after capture.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_IRQ     = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL = 5'd8;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF   = 5'd10;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF     = 5'd12;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_VECTOR = 2'd2
  } pcSelE;

  typedef enum logic [1:0] {
    SRC_ID  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2
  } epcSrcE;

  typedef struct packed {
    logic               flushIf;
    logic               flushId;
    logic               flushEx;
    logic               killMemWr;
    logic               capture;
    epcSrcE             epcSrc;
    logic [CAUSE_W-1:0] causeCode;
    pcSelE              pcSel;
  } strobeT;
endpackage

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import prc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   brTaken,
  input  logic   idUndef,
  input  logic   idSyscall,
  input  logic   exOvf,
  input  logic   memIrq,
  output strobeT stb
);
  // fault per stage, index 0 = decode, 1 = execute, 2 = memory (oldest)
  localparam int NSTG = 3;
  logic [NSTG-1:0] rawFault;
  logic [NSTG-1:0] winFault;
  logic            anyFault;
  logic            branchGo;

  assign rawFault = {memIrq, exOvf, idUndef | idSyscall};
  assign anyFault = |rawFault;
  assign branchGo = brTaken & ~anyFault;

  // oldest stage wins: a stage wins if no older stage faults
  for (genvar s = 0; s < NSTG; s++) begin : g_win
    if (s == NSTG - 1) begin : g_top
      assign winFault[s] = rawFault[s];
    end else begin : g_lower
      assign winFault[s] = rawFault[s] & ~(|rawFault[NSTG-1:s+1]);
    end
  end

  always_comb begin
    stb           = '0;
    stb.pcSel     = PC_SEQ;
    stb.epcSrc    = SRC_ID;
    stb.causeCode = CAUSE_IRQ;
    // every fault or redirect leaves fetch and decode on a wrong path
    stb.flushIf   = anyFault | branchGo;
    stb.flushId   = anyFault | branchGo;
    stb.flushEx   = branchGo | winFault[1] | winFault[2];
    stb.killMemWr = winFault[2];
    stb.capture   = anyFault;
    if (anyFault) begin
      stb.pcSel = PC_VECTOR;
    end else if (branchGo) begin
      stb.pcSel = PC_BRANCH;
    end
    if (winFault[2]) begin
      stb.epcSrc    = SRC_MEM;
      stb.causeCode = CAUSE_IRQ;
    end else if (winFault[1]) begin
      stb.epcSrc    = SRC_EX;
      stb.causeCode = CAUSE_OVF;
    end else if (winFault[0]) begin
      stb.epcSrc    = SRC_ID;
      stb.causeCode = idUndef ? CAUSE_UNDEF : CAUSE_SYSCALL;
    end
  end

  assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winFault));
  assert_fault_beats_branch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && anyFault) |-> (stb.pcSel == PC_VECTOR));
  assert_branch_squash_R3: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && !anyFault) |-> (stb.flushIf && stb.flushId && stb.flushEx && !stb.killMemWr));
  assert_irq_kills_mem_R10: assert property (@(posedge clk) disable iff (!rstN)
    memIrq |-> (stb.killMemWr && stb.flushEx && stb.causeCode == CAUSE_IRQ));
  assert_id_fault_spares_ex_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((idUndef || idSyscall) && !exOvf && !memIrq && !brTaken) |-> !stb.flushEx);
endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          IW     = 32,
  parameter int          CW     = 8,
  parameter int          DW     = 32,
  parameter logic [AW-1:0] VECTOR = 32'h4000_0040
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [AW-1:0]      pcPlus4,
  input  logic [AW-1:0]      brTarget,
  input  logic [AW-1:0]      idPc,
  input  logic [AW-1:0]      exPc,
  input  logic [AW-1:0]      memPc,
  input  logic [IW-1:0]      ifIdInstrIn,
  input  logic [CW-1:0]      idCtrlIn,
  input  logic [DW-1:0]      exAluIn,
  input  logic               exWrEnIn,
  input  logic               memWrEnIn,
  output logic [AW-1:0]      nextPc,
  output logic [IW-1:0]      ifIdInstrOut,
  output logic [CW-1:0]      idCtrlOut,
  output logic [DW-1:0]      exAluOut,
  output logic               exWrEnOut,
  output logic               memWrEnOut,
  output logic [AW-1:0]      epcQ,
  output logic [CAUSE_W-1:0] causeQ
);
  logic [AW-1:0] faultPc;

  always_comb begin
    unique case (stb.pcSel)
      PC_BRANCH: nextPc = brTarget;
      PC_VECTOR: nextPc = VECTOR;
      default:   nextPc = pcPlus4;
    endcase
  end

  // per-stage squash muxes
  assign ifIdInstrOut = stb.flushIf ? '0 : ifIdInstrIn;
  assign idCtrlOut    = stb.flushId ? '0 : idCtrlIn;
  assign exAluOut     = stb.flushEx ? '0 : exAluIn;
  assign exWrEnOut    = exWrEnIn & ~stb.flushEx;
  assign memWrEnOut   = memWrEnIn & ~stb.killMemWr;

  always_comb begin
    unique case (stb.epcSrc)
      SRC_MEM: faultPc = memPc;
      SRC_EX:  faultPc = exPc;
      default: faultPc = idPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ   <= '0;
      causeQ <= '0;
    end else if (stb.capture) begin
      epcQ   <= faultPc;
      causeQ <= stb.causeCode;
    end
  end

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> ($stable(epcQ) && $stable(causeQ)));
  assert_vector_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pcSel == PC_VECTOR) |-> (nextPc == VECTOR));
  assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && stb.epcSrc == SRC_EX) |-> (!exWrEnOut && exAluOut == '0));
  assert_capture_loads_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && stb.epcSrc == SRC_MEM) |=> (epcQ == $past(memPc)));
endmodule

// File: rtl/pipe_redirect_ctrl.sv
module pipe_redirect_ctrl
  import prc_pkg::*;
#(
  parameter int            AW     = 32,
  parameter int            IW     = 32,
  parameter int            CW     = 8,
  parameter int            DW     = 32,
  parameter logic [AW-1:0] VECTOR = 32'h4000_0040
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               brTaken,
  input  logic [AW-1:0]      brTarget,
  input  logic [AW-1:0]      pcPlus4,
  input  logic [AW-1:0]      idPc,
  input  logic [AW-1:0]      exPc,
  input  logic [AW-1:0]      memPc,
  input  logic               idUndef,
  input  logic               idSyscall,
  input  logic               exOvf,
  input  logic               memIrq,
  input  logic [IW-1:0]      ifIdInstrIn,
  input  logic [CW-1:0]      idCtrlIn,
  input  logic [DW-1:0]      exAluIn,
  input  logic               exWrEnIn,
  input  logic               memWrEnIn,
  output logic [1:0]         pcSel,
  output logic [AW-1:0]      nextPc,
  output logic               flushIfId,
  output logic               flushIdEx,
  output logic               flushExMem,
  output logic [IW-1:0]      ifIdInstrOut,
  output logic [CW-1:0]      idCtrlOut,
  output logic [DW-1:0]      exAluOut,
  output logic               exWrEnOut,
  output logic               memWrEnOut,
  output logic [AW-1:0]      epc,
  output logic [CAUSE_W-1:0] cause
);
  strobeT stb;

  prc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .brTaken(brTaken), .idUndef(idUndef),
    .idSyscall(idSyscall), .exOvf(exOvf), .memIrq(memIrq), .stb(stb)
  );

  prc_datapath #(.AW(AW), .IW(IW), .CW(CW), .DW(DW), .VECTOR(VECTOR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pcPlus4(pcPlus4), .brTarget(brTarget),
    .idPc(idPc), .exPc(exPc), .memPc(memPc), .ifIdInstrIn(ifIdInstrIn),
    .idCtrlIn(idCtrlIn), .exAluIn(exAluIn), .exWrEnIn(exWrEnIn),
    .memWrEnIn(memWrEnIn), .nextPc(nextPc), .ifIdInstrOut(ifIdInstrOut),
    .idCtrlOut(idCtrlOut), .exAluOut(exAluOut), .exWrEnOut(exWrEnOut),
    .memWrEnOut(memWrEnOut), .epcQ(epc), .causeQ(cause)
  );

  assign pcSel      = stb.pcSel;
  assign flushIfId  = stb.flushIf;
  assign flushIdEx  = stb.flushId;
  assign flushExMem = stb.flushEx;
endmodule

// File: tb/pipe_redirect_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_redirect_ctrl_tb;
  localparam logic [31:0] VEC = 32'h4000_0040;
  localparam logic [31:0] P4 = 32'h0000_1010, TGT = 32'h0000_2000;
  localparam logic [31:0] PID = 32'h0000_100C, PEX = 32'h0000_1008, PMEM = 32'h0000_1004;
  localparam logic [31:0] INSTR = 32'hDEAD_BEEF, ALU = 32'h1234_5678;
  localparam logic [7:0]  CTL = 8'hA5;

  logic clk = 0, rstN = 0;
  logic brTaken = 0, idUndef = 0, idSyscall = 0, exOvf = 0, memIrq = 0;
  logic [31:0] brTarget = TGT, pcPlus4 = P4, idPc = PID, exPc = PEX, memPc = PMEM;
  logic [31:0] ifIdInstrIn = INSTR, exAluIn = ALU;
  logic [7:0]  idCtrlIn = CTL;
  logic exWrEnIn = 1, memWrEnIn = 1;
  logic [1:0] pcSel;
  logic [31:0] nextPc, ifIdInstrOut, exAluOut, epc;
  logic [7:0] idCtrlOut;
  logic flushIfId, flushIdEx, flushExMem, exWrEnOut, memWrEnOut;
  logic [4:0] cause;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_redirect_ctrl u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    brTaken = 0; idUndef = 0; idSyscall = 0; exOvf = 0; memIrq = 0;
  endtask

  task automatic chkPass(input string tag);
    chk({31'd0, flushIfId}, 0, {tag, " flushIfId"});
    chk(ifIdInstrOut, INSTR, {tag, " instr"});
    chk({24'd0, idCtrlOut}, {24'd0, CTL}, {tag, " ctrl"});
    chk(exAluOut, ALU, {tag, " alu"});
    chk({31'd0, exWrEnOut}, 1, {tag, " exWrEn"});
    chk({31'd0, memWrEnOut}, 1, {tag, " memWrEn"});
  endtask

  task automatic test_reset();
    chk(epc, 0, "R1 epc");
    chk({27'd0, cause}, 0, "R1 cause");
    chk({30'd0, pcSel}, 0, "R1 pcSel");
  endtask

  task automatic test_idle();
    @(negedge clk); clearIn(); #1;
    chk({30'd0, pcSel}, 0, "R2 pcSel");
    chk(nextPc, P4, "R2 nextPc");
    chkPass("R2");
    chk({31'd0, flushExMem}, 0, "R2 flushExMem");
  endtask

  task automatic test_branch();
    logic [31:0] e0; logic [4:0] c0;
    e0 = epc; c0 = cause;
    @(negedge clk); brTaken = 1; #1;
    chk({30'd0, pcSel}, 1, "R3 pcSel");
    chk(nextPc, TGT, "R3 nextPc");
    chk({29'd0, flushIfId, flushIdEx, flushExMem}, 7, "R3 flushes");
    chk(ifIdInstrOut, 0, "R3 instr zero");
    chk({24'd0, idCtrlOut}, 0, "R3 ctrl zero");
    chk(exAluOut, 0, "R3 alu zero");
    chk({31'd0, exWrEnOut}, 0, "R3 exWrEn");
    chk({31'd0, memWrEnOut}, 1, "R3 memWrEn kept");
    @(posedge clk); #1;
    chk(epc, e0, "R11 epc hold on branch");
    chk({27'd0, cause}, {27'd0, c0}, "R11 cause hold on branch");
    @(negedge clk); clearIn();
  endtask

  task automatic test_ovf();
    @(negedge clk); exOvf = 1; #1;
    chk({30'd0, pcSel}, 2, "R4 pcSel");
    chk(nextPc, VEC, "R4 nextPc");
    chk({29'd0, flushIfId, flushIdEx, flushExMem}, 7, "R8 flushes");
    chk(exAluOut, 0, "R8 alu zero");
    chk({31'd0, exWrEnOut}, 0, "R8 exWrEn killed");
    chk({31'd0, memWrEnOut}, 1, "R8 older completes");
    @(posedge clk); #1;
    chk(epc, PEX, "R5 epc ovf");
    chk({27'd0, cause}, 12, "R5 cause ovf");
    @(negedge clk); clearIn(); #1;
    @(posedge clk); #1;
    chk(epc, PEX, "R11 epc hold idle");
    chk({27'd0, cause}, 12, "R11 cause hold idle");
  endtask

  task automatic test_id(input bit undef, input bit sys, input logic [4:0] code, input string tag);
    @(negedge clk); idUndef = undef; idSyscall = sys; #1;
    chk({30'd0, pcSel}, 2, {tag, " pcSel"});
    chk({29'd0, flushIfId, flushIdEx, flushExMem}, 6, {tag, " flushes"});
    chk(exAluOut, ALU, {tag, " alu kept"});
    chk({31'd0, exWrEnOut}, 1, {tag, " exWrEn kept"});
    chk({24'd0, idCtrlOut}, 0, {tag, " ctrl zero"});
    @(posedge clk); #1;
    chk(epc, PID, {tag, " epc"});
    chk({27'd0, cause}, {27'd0, code}, {tag, " cause"});
    @(negedge clk); clearIn();
  endtask

  task automatic test_irq();
    @(negedge clk); memIrq = 1; #1;
    chk({29'd0, flushIfId, flushIdEx, flushExMem}, 7, "R10 flushes");
    chk({31'd0, memWrEnOut}, 0, "R10 memWrEn killed");
    chk(nextPc, VEC, "R10 nextPc");
    @(posedge clk); #1;
    chk(epc, PMEM, "R10 epc");
    chk({27'd0, cause}, 0, "R5 cause irq");
    @(negedge clk); clearIn();
  endtask

  task automatic test_priority();
    // execute beats decode: overflow code 12 and execute PC
    @(negedge clk); exOvf = 1; idSyscall = 1; #1;
    chk({31'd0, flushExMem}, 1, "R6 ex over id flush");
    @(posedge clk); #1;
    chk(epc, PEX, "R6 ex over id epc");
    chk({27'd0, cause}, 12, "R6 ex over id cause");
    @(negedge clk); clearIn();
    // memory beats everything
    @(negedge clk); memIrq = 1; exOvf = 1; idUndef = 1; #1;
    chk({31'd0, memWrEnOut}, 0, "R6 mem wins kill");
    @(posedge clk); #1;
    chk(epc, PMEM, "R6 mem wins epc");
    chk({27'd0, cause}, 0, "R6 mem wins cause");
    @(negedge clk); clearIn();
  endtask

  task automatic test_exc_vs_branch();
    @(negedge clk); brTaken = 1; idSyscall = 1; #1;
    chk({30'd0, pcSel}, 2, "R7 pcSel");
    chk(nextPc, VEC, "R7 nextPc");
    @(posedge clk); #1;
    chk({27'd0, cause}, 8, "R7 cause syscall");
    @(negedge clk); clearIn();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; test_reset();
    @(negedge clk); rstN = 1;
    test_idle();
    test_branch();
    test_ovf();
    test_id(1, 0, 5'd10, "R9 undef");
    test_id(0, 1, 5'd8, "R9 syscall");
    test_id(1, 1, 5'd10, "R6 undef over syscall");
    test_irq();
    test_priority();
    test_exc_vs_branch();
    test_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule